// File: doc/BRIEF.md
# Receive Byte Queue with Fill Threshold

This block is the receive-side holding queue of a serial controller. Bytes produced by the deserialiser are written into a sixteen-entry circular store while reception is enabled. A processor read port takes them out in arrival order. The block keeps a running fill count and compares it against a trigger level picked from four fixed values by a two-bit select. When the count reaches that level, a data-full flag is raised. The same condition, gated by an interrupt enable, drives a receive interrupt line.

The flag is updated only by queue traffic. A stored byte that brings the count to or above the level sets it. A pop that leaves the count below the level clears it. A one-cycle clear strobe discards everything queued and drops the flag at once. Software can read the number of stored bytes at any time on a dedicated count output.

Top module: `rxTrigFifo`

## Requirements
- R1: After reset the fill count is 0, the data-full flag and the interrupt are low, and a pop returns 0.
- R2: Up to 16 bytes are held and returned in arrival order, including when the internal pointers wrap past entry 15. The count output equals the number of stored bytes one cycle after each push or pop.
- R3: The trigger level is 1 for select 00, 4 for 01, 8 for 10 and 14 for 11. The data-full flag is high in the cycle after a push brings the count to or above the level.
- R4: A pop that leaves the count below the trigger level clears the data-full flag in the following cycle. A pop that leaves it at or above the level keeps the flag high.
- R5: A byte offered while the count is 16 is dropped. The count stays at 16 and the queued contents are unchanged.
- R6: A clear strobe empties the queue and lowers the flag on the next cycle. It wins over a push or pop in the same cycle, and discarded bytes are never returned.
- R7: A byte offered while the receive-enable input is low is ignored.
- R8: The interrupt output is high exactly when the data-full flag is high and the interrupt-enable input is high.
- R9: A pop on an empty queue returns 0 and leaves the count unchanged.
- R10: A push and a pop in the same cycle on a non-empty, non-full queue are both carried out. The count is unchanged and the popped byte is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Incoming byte strobe |
| byteIn | input | 8 | Incoming byte |
| popStb | input | 1 | Read strobe; popData is valid in the same cycle |
| popData | output | 8 | Oldest byte during an accepted pop, else 0 |
| trigSel | input | 2 | Trigger level select (00:1, 01:4, 10:8, 11:14) |
| fifoClr | input | 1 | Queue clear strobe |
| rxEnable | input | 1 | Allows bytes to be stored |
| irqEnable | input | 1 | Gates the interrupt output |
| fillCount | output | 5 | Number of stored bytes |
| dataFull | output | 1 | Fill threshold flag |
| rxIrq | output | 1 | Receive interrupt |

## Verification
On every cycle, the assertions check several properties. The count never exceeds sixteen. A full queue with no pop holds its count. A clear always leaves an empty queue with the flag down. A raised flag never coexists with an empty queue. Disabled reception never grows the count. A simultaneous push and pop leaves the count unchanged, and the read pointer wraps to entry 0. Other behaviour can only be shown by the bench scenarios: that bytes come back in order across the wrap, that each of the four levels trips the flag at the exact count, and that dropped or cleared bytes never reappear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Qualified per-cycle actions from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxqStb_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic          rxEnable,
  input  logic          popStb,
  input  logic          fifoClr,
  input  logic [1:0]    trigSel,
  input  logic          irqEnable,
  output rxqStb_t       stb,
  output logic [CW-1:0] count,
  output logic          dataFull,
  output logic          rxIrq
);
  logic [CW-1:0] trigLevel;
  logic [CW-1:0] cntNext;
  logic          flagNext;
  logic          notFull;
  logic          notEmpty;

  always_comb begin
    case (trigSel)
      2'b00:   trigLevel = CW'(LVL0);
      2'b01:   trigLevel = CW'(LVL1);
      2'b10:   trigLevel = CW'(LVL2);
      default: trigLevel = CW'(LVL3);
    endcase
  end

  assign notFull  = (count != CW'(DEPTH));
  assign notEmpty = (count != '0);

  always_comb begin
    stb.clear = fifoClr;
    stb.push  = byteValid && rxEnable && notFull && !fifoClr;
    stb.pop   = popStb && notEmpty && !fifoClr;
  end

  always_comb begin
    if (stb.clear) begin
      cntNext = '0;
    end else begin
      case ({stb.push, stb.pop})
        2'b10:   cntNext = count + CW'(1);
        2'b01:   cntNext = count - CW'(1);
        default: cntNext = count;
      endcase
    end
  end

  always_comb begin
    if (stb.clear)                              flagNext = 1'b0;
    else if (stb.push && cntNext >= trigLevel)  flagNext = 1'b1;
    else if (stb.pop && cntNext < trigLevel)    flagNext = 1'b0;
    else                                        flagNext = dataFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      dataFull <= 1'b0;
    end else begin
      count    <= cntNext;
      dataFull <= flagNext;
    end
  end

  assign rxIrq = dataFull & irqEnable;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (count == CW'(DEPTH) && !popStb && !fifoClr) |=> count == CW'(DEPTH)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (count == '0 && !dataFull)); // R6
  AST_FLAG_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    dataFull |-> count != '0); // R3
  AST_RX_OFF_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> count <= $past(count)); // R7
  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.pop) |=> count == $past(count)); // R10
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStb_t          stb,
  input  logic [WIDTH-1:0] byteIn,
  output logic [WIDTH-1:0] popData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               mem[i] <= '0;
      else if (stb.clear)                      mem[i] <= '0;
      else if (stb.push && wrPtr == PW'(i))    mem[i] <= byteIn;
    end
  end

  assign popData = stb.pop ? mem[rdPtr] : '0;

  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.clear && rdPtr == PW'(DEPTH - 1)) |=> rdPtr == '0); // R2
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !stb.clear) |=> wrPtr != $past(wrPtr)); // R2
endmodule

// File: rtl/rxTrigFifo.sv
module rxTrigFifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [WIDTH-1:0] byteIn,
  input  logic             popStb,
  output logic [WIDTH-1:0] popData,
  input  logic [1:0]       trigSel,
  input  logic             fifoClr,
  input  logic             rxEnable,
  input  logic             irqEnable,
  output logic [CW-1:0]    fillCount,
  output logic             dataFull,
  output logic             rxIrq
);
  rxqStb_t stb;

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxEnable(rxEnable),
    .popStb(popStb), .fifoClr(fifoClr), .trigSel(trigSel),
    .irqEnable(irqEnable), .stb(stb), .count(fillCount),
    .dataFull(dataFull), .rxIrq(rxIrq)
  );

  rxq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIn(byteIn), .popData(popData)
  );
endmodule

// File: tb/sim_rxTrigFifo.sv
module sim_rxTrigFifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic popStb = 1'b0;
  logic [7:0] popData;
  logic [1:0] trigSel = 2'b00;
  logic fifoClr = 1'b0;
  logic rxEnable = 1'b1;
  logic irqEnable = 1'b0;
  logic [4:0] fillCount;
  logic dataFull;
  logic rxIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxTrigFifo u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .popStb(popStb), .popData(popData), .trigSel(trigSel), .fifoClr(fifoClr),
    .rxEnable(rxEnable), .irqEnable(irqEnable), .fillCount(fillCount),
    .dataFull(dataFull), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1; byteIn = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic popByte(output logic [7:0] d);
    @(negedge clk);
    popStb = 1'b1;
    #1 d = popData;
    @(negedge clk);
    popStb = 1'b0;
  endtask

  task automatic clearQ();
    @(negedge clk);
    fifoClr = 1'b1;
    @(negedge clk);
    fifoClr = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 5) & 255);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lvl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", fillCount, 0);
    chk("R1 flag", dataFull, 0);
    chk("R1 irq", rxIrq, 0);
    popByte(d);
    chk("R1/R9 empty pop data", d, 0);
    chk("R9 count after empty pop", fillCount, 0);

    // Sweep all four trigger levels, with pointer offsets to force wrap
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      irqEnable = s[0];
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      clearQ();
      for (int j = 0; j < s * 5; j++) pushByte(8'(200 + j));
      for (int j = 0; j < s * 5; j++) begin
        popByte(d);
        chk("R2 offset order", d, 200 + j);
      end
      for (int k = 1; k <= 16; k++) begin
        pushByte(pat(s, k));
        chk("R2 count on push", fillCount, k);
        chk("R3 flag on push", dataFull, int'(k >= lvl));
        chk("R8 irq", rxIrq, int'(k >= lvl && s[0]));
      end
      pushByte(8'hEE);
      chk("R5 full drop count", fillCount, 16);
      for (int k = 1; k <= 16; k++) begin
        popByte(d);
        chk("R2/R5 pop order", d, pat(s, k));
        chk("R2 count on pop", fillCount, 16 - k);
        chk("R4 flag on pop", dataFull, int'((16 - k) >= lvl));
      end
    end

    // R7 receive disabled
    trigSel = 2'b00; irqEnable = 1'b1;
    rxEnable = 1'b0;
    pushByte(8'h55);
    chk("R7 count", fillCount, 0);
    chk("R7 flag", dataFull, 0);
    rxEnable = 1'b1;

    // R10 simultaneous push and pop
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    @(negedge clk);
    byteValid = 1'b1; byteIn = 8'h44; popStb = 1'b1;
    #1 chk("R10 popped oldest", popData, 8'h11);
    @(negedge clk);
    byteValid = 1'b0; popStb = 1'b0;
    chk("R10 count kept", fillCount, 3);
    popByte(d); chk("R10 order a", d, 8'h22);
    popByte(d); chk("R10 order b", d, 8'h33);
    popByte(d); chk("R10 order c", d, 8'h44);
    chk("R4 flag after drain", dataFull, 0);
    chk("R8 irq after drain", rxIrq, 0);

    // R8 irq follows enable
    pushByte(8'h66);
    chk("R8 irq enabled", rxIrq, 1);
    irqEnable = 1'b0;
    #1 chk("R8 irq gated", rxIrq, 0);

    // R6 clear wins over a same-cycle push
    pushByte(8'h77);
    @(negedge clk);
    fifoClr = 1'b1; byteValid = 1'b1; byteIn = 8'h88;
    @(negedge clk);
    fifoClr = 1'b0; byteValid = 1'b0;
    chk("R6 count", fillCount, 0);
    chk("R6 flag", dataFull, 0);
    popByte(d);
    chk("R6/R9 nothing left", d, 0);
    pushByte(8'h99);
    popByte(d);
    chk("R6 fresh after clear", d, 8'h99);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule